// File: doc/BRIEF.md
# HDB3 Channel Codec with Loopback

This block is the digital data path of one E1 channel. On the transmit side it takes one data bit per clock and produces a pair of line rails in HDB3 code. On the receive side it takes a pair of rails and produces single-rail data together with a code-violation flag. The analog front end sits outside the block. Clock recovery and jitter handling are also outside it, so everything runs on one clock.

Three overrides surround the codec. A transmit all-ones control replaces the outgoing data with marks. An automatic all-ones control replaces the receive outputs with ones while the line reports loss of signal. A loopback control feeds the encoded transmit rails straight into the decoder, and the encoded rails keep driving the line. A mode input selects plain alternate mark inversion (AMI) instead of HDB3 for both directions.

Encoder and decoder each take four register stages. A bit therefore reaches the line three cycles after it is sampled. In loopback it returns on the receive data output seven cycles after it is sampled.

Top module: `hdb3_channel_codec`

## Requirements
- R1: `line_tx_pos` high marks a positive pulse and `line_tx_neg` high marks a negative pulse. The two are never high together. Every mark other than a substitution violation takes the polarity opposite to the previous mark. The first mark after reset is positive.
- R2: With `ami_sel` low, each run of four zero bits is replaced on the line. The replacement is zero-zero-zero-V when an odd number of marks has gone out since the last violation, and B-zero-zero-V when the count is even. The count is even after reset. B follows the normal alternation, V repeats the polarity of the mark before it, and V clears the count. The line shows the symbol for a bit sampled at rising edge n from just after edge n+3 onward.
- R3: With `ami_sel` high there is no substitution. Each one bit becomes an alternating mark and each zero bit becomes an empty symbol, with the latency of R2.
- R4: While `tx_ones_en` is high, input bits are taken as ones regardless of `tx_data`. The line carries an unbroken train of alternating marks with the latency of R2.
- R5: `rx_data` is 1 for a received mark and 0 for an empty symbol, three cycles after the symbol is sampled. In HDB3 mode a valid violation is removed and output as 0, together with the three positions before it. A valid violation is a mark with the same polarity as the previous mark, where neither of the two preceding positions held a mark.
- R6: `rx_cv` is high in the position of a same-polarity mark that is not a valid violation. In AMI mode every same-polarity mark counts. In HDB3 mode `rx_cv` is also high on the fourth and every later zero of a run. Neither case is flagged before the first mark received after reset.
- R7: When `auto_rx_ones_en` and `rx_los` are both high and loopback is off, then after the next edge `rx_data` is 1 and `rx_cv` is 0.
- R8: With `loopback_en` high the decoder reads the encoded transmit rails. `rx_data` then equals the bit sampled seven edges earlier and `rx_cv` stays low. The line receive rails and `rx_los` have no effect, and the line transmit rails keep running.
- R9: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ami_sel | input | 1 | 1 selects AMI, 0 selects HDB3 |
| tx_data | input | 1 | Single-rail transmit bit |
| tx_ones_en | input | 1 | Force transmit data to all ones |
| loopback_en | input | 1 | Route transmit rails into the decoder |
| line_rx_pos | input | 1 | Positive pulse received from the line |
| line_rx_neg | input | 1 | Negative pulse received from the line |
| rx_los | input | 1 | Line loss-of-signal indication |
| auto_rx_ones_en | input | 1 | Allow ones substitution on loss of signal |
| line_tx_pos | output | 1 | Positive pulse toward the line |
| line_tx_neg | output | 1 | Negative pulse toward the line |
| rx_data | output | 1 | Decoded single-rail receive data |
| rx_cv | output | 1 | Line code violation flag |

## Verification
Dense random data makes substitutions rare, so alternation errors show up on their own. Sparse data produces long zero runs, where the odd and even parity choice between the two substitution forms decides every violation's polarity. Directed zero runs right after reset pin down the even start. Random bursts of forced ones separate the override from ordinary data. Decoder-only runs feed random rails with frequent same-polarity marks, which separates valid violations, removed with their three predecessors, from flagged ones. Loopback runs inject line noise and random loss-of-signal, which shows that the line input and the ones substitution are both shut out.

// File: rtl/hdb3_channel_codec.sv
module hdb3_channel_codec (
  input  logic clk,
  input  logic rst_n,
  input  logic ami_sel,
  input  logic tx_data,
  input  logic tx_ones_en,
  input  logic loopback_en,
  input  logic line_rx_pos,
  input  logic line_rx_neg,
  input  logic rx_los,
  input  logic auto_rx_ones_en,
  output logic line_tx_pos,
  output logic line_tx_neg,
  output logic rx_data,
  output logic rx_cv
);

  logic [2:0] enc_mark, enc_viol;
  logic       enc_last_pos, enc_odd;
  logic       tx_bit, subst, b_pulse, emit;

  assign tx_bit  = tx_data | tx_ones_en;
  assign subst   = !ami_sel && !tx_bit && (enc_mark == 3'b000);
  assign b_pulse = subst && !enc_odd;
  assign emit    = enc_mark[2] | b_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_mark     <= '0;
      enc_viol     <= '0;
      enc_last_pos <= 1'b0;
      enc_odd      <= 1'b0;
      line_tx_pos  <= 1'b0;
      line_tx_neg  <= 1'b0;
    end else begin
      enc_mark <= {enc_mark[1:0], tx_bit | subst};
      enc_viol <= {enc_viol[1:0], subst};
      if (!emit) begin
        line_tx_pos <= 1'b0;
        line_tx_neg <= 1'b0;
      end else if (enc_viol[2]) begin
        line_tx_pos <= enc_last_pos;
        line_tx_neg <= !enc_last_pos;
        enc_odd     <= 1'b0;
      end else begin
        line_tx_pos  <= !enc_last_pos;
        line_tx_neg  <= enc_last_pos;
        enc_last_pos <= !enc_last_pos;
        enc_odd      <= !enc_odd;
      end
    end
  end

  logic [1:0] dec_in, raw_mark, zrun;
  logic [2:0] dec_data, dec_cv;
  logic       dec_last_pos, dec_seen;
  logic       in_mark, same_pol, v_ok, cv_now, ais;

  assign dec_in   = loopback_en ? {line_tx_pos, line_tx_neg} : {line_rx_pos, line_rx_neg};
  assign in_mark  = |dec_in;
  assign same_pol = in_mark && dec_seen && (dec_in[1] == dec_last_pos);
  assign v_ok     = same_pol && !ami_sel && (raw_mark == 2'b00);
  assign cv_now   = (same_pol && !v_ok) ||
                    (!in_mark && !ami_sel && dec_seen && zrun == 2'd3);
  assign ais      = auto_rx_ones_en && rx_los && !loopback_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_mark     <= '0;
      zrun         <= '0;
      dec_data     <= '0;
      dec_cv       <= '0;
      dec_last_pos <= 1'b0;
      dec_seen     <= 1'b0;
      rx_data      <= 1'b0;
      rx_cv        <= 1'b0;
    end else begin
      raw_mark <= {raw_mark[0], in_mark};
      dec_cv   <= {dec_cv[1:0], cv_now};
      dec_data <= v_ok ? 3'b000 : {dec_data[1:0], in_mark};
      rx_data  <= ais | (dec_data[2] & !v_ok);
      rx_cv    <= !ais & dec_cv[2];
      if (in_mark) begin
        dec_last_pos <= dec_in[1];
        dec_seen     <= 1'b1;
        zrun         <= '0;
      end else if (zrun != 2'd3) begin
        zrun <= zrun + 2'd1;
      end
    end
  end

endmodule

// File: rtl/hdb3_channel_codec_chk.sv
module hdb3_channel_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic ami_sel,
  input logic tx_ones_en,
  input logic loopback_en,
  input logic rx_los,
  input logic auto_rx_ones_en,
  input logic line_tx_pos,
  input logic line_tx_neg,
  input logic rx_data,
  input logic rx_cv
);

  logic [2:0] gap, ones_cnt;
  logic       seen_mark, ch_last_pos;
  logic       line_mark;

  assign line_mark = line_tx_pos | line_tx_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap         <= '0;
      ones_cnt    <= '0;
      seen_mark   <= 1'b0;
      ch_last_pos <= 1'b0;
    end else begin
      if (line_mark) begin
        seen_mark   <= 1'b1;
        ch_last_pos <= line_tx_pos;
      end
      if (ami_sel || line_mark || !seen_mark) gap <= '0;
      else if (gap != 3'd7) gap <= gap + 3'd1;
      if (!tx_ones_en) ones_cnt <= '0;
      else if (ones_cnt != 3'd4) ones_cnt <= ones_cnt + 3'd1;
    end
  end

  // R2
  no_long_zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ami_sel && seen_mark && !line_mark) |-> (gap < 3'd3));

  // R4
  ones_give_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_cnt == 3'd4) |-> (line_tx_pos ^ line_tx_neg));

  // R3
  ami_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ami_sel && seen_mark && (line_tx_pos ^ line_tx_neg)) |-> (line_tx_pos != ch_last_pos));

  // R7
  auto_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rx_ones_en && rx_los && !loopback_en) |=> (rx_data && !rx_cv));

endmodule

bind hdb3_channel_codec hdb3_channel_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ami_sel(ami_sel), .tx_ones_en(tx_ones_en),
  .loopback_en(loopback_en), .rx_los(rx_los), .auto_rx_ones_en(auto_rx_ones_en),
  .line_tx_pos(line_tx_pos), .line_tx_neg(line_tx_neg),
  .rx_data(rx_data), .rx_cv(rx_cv)
);

// File: tb/hdb3_channel_codec_bench.sv
`timescale 1ns/1ps
module hdb3_channel_codec_bench;
  localparam int MAXN = 1600;
  localparam int SZ   = MAXN + 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ami_sel, tx_data, tx_ones_en, loopback_en;
  logic line_rx_pos, line_rx_neg, rx_los, auto_rx_ones_en;
  logic line_tx_pos, line_tx_neg, rx_data, rx_cv;

  hdb3_channel_codec u_hdb3_channel_codec (
    .clk(clk), .rst_n(rst_n), .ami_sel(ami_sel), .tx_data(tx_data),
    .tx_ones_en(tx_ones_en), .loopback_en(loopback_en),
    .line_rx_pos(line_rx_pos), .line_rx_neg(line_rx_neg), .rx_los(rx_los),
    .auto_rx_ones_en(auto_rx_ones_en), .line_tx_pos(line_tx_pos),
    .line_tx_neg(line_tx_neg), .rx_data(rx_data), .rx_cv(rx_cv)
  );

  int checks = 0, errors = 0;

  bit         s    [0:SZ];
  bit         asg  [0:SZ];
  int         code [0:SZ];
  logic [1:0] lsym [0:SZ];
  logic [1:0] rsym [0:SZ];
  bit         ais_q[0:SZ];
  bit         rawm [0:SZ];
  bit         dat  [0:SZ];
  bit         cvb  [0:SZ];
  bit elast, eodd, dlast, dseen;
  int zr;

  task automatic check1(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  // reference HDB3/AMI encoder for stream position p
  task automatic resolve(input int p, input bit ami);
    if (!asg[p]) begin
      if (!ami && !s[p] && !s[p+1] && !s[p+2] && !s[p+3]) begin
        code[p] = eodd ? 0 : 2;
        code[p+1] = 0; code[p+2] = 0; code[p+3] = 3;
        asg[p+1] = 1; asg[p+2] = 1; asg[p+3] = 1;
      end else code[p] = s[p] ? 1 : 0;
    end
    case (code[p])
      0: lsym[p] = 2'b00;
      3: begin lsym[p] = elast ? 2'b10 : 2'b01; eodd = 0; end
      default: begin elast = !elast; lsym[p] = elast ? 2'b10 : 2'b01; eodd = !eodd; end
    endcase
  endtask

  // reference decoder for input position e
  task automatic decode(input int e, input logic [1:0] sym, input bit ami);
    bit mk, ps, same, m1, m2;
    mk = (sym != 2'b00);
    ps = sym[1];
    rawm[e] = mk;
    if (mk) begin
      same = dseen && (ps == dlast);
      m1 = (e >= 1) ? rawm[e-1] : 1'b0;
      m2 = (e >= 2) ? rawm[e-2] : 1'b0;
      if (same && !ami && !m1 && !m2) begin
        dat[e] = 0; cvb[e] = 0;
        for (int k = 1; k <= 3; k++) if (e - k >= 0) dat[e-k] = 0;
      end else begin
        dat[e] = 1; cvb[e] = same;
      end
      dlast = ps; dseen = 1; zr = 0;
    end else begin
      dat[e] = 0;
      cvb[e] = !ami && dseen && (zr >= 3);
      if (zr < 3) zr++;
    end
  endtask

  function automatic bit directed_bit(input int c);
    return (c == 10) || (c == 15) || (c == 16) || (c > 20 && c < 24);
  endfunction

  task automatic run_phase(input int n, input bit ami, input bit lb, input int p_one,
                           input int p_tog, input int p_rx, input bit directed);
    int idx;
    bit ed, ecv, ones;
    string ltag, rtag;
    ami_sel = ami; loopback_en = lb; rst_n = 1'b0;
    tx_data = 0; tx_ones_en = 0; line_rx_pos = 0; line_rx_neg = 0;
    rx_los = 0; auto_rx_ones_en = 0;
    for (int i = 0; i <= SZ; i++) begin
      s[i] = 0; asg[i] = 0; code[i] = 0; lsym[i] = 0; rsym[i] = 0;
      ais_q[i] = 0; rawm[i] = 0; dat[i] = 0; cvb[i] = 0;
    end
    elast = 0; eodd = 0; dlast = 0; dseen = 0; zr = 0; ones = 0;
    repeat (3) @(negedge clk);
    check1(line_tx_pos, 1'b0, "R9", "line_tx_pos in reset");
    check1(line_tx_neg, 1'b0, "R9", "line_tx_neg in reset");
    check1(rx_data, 1'b0, "R9", "rx_data in reset");
    check1(rx_cv, 1'b0, "R9", "rx_cv in reset");
    rst_n = 1'b1;
    ltag = ami ? "R3" : "R1/R2/R4";
    for (int c = 0; c <= n; c++) begin
      if (c > 0) begin
        @(negedge clk);
        resolve(c - 1, ami);
        check1(line_tx_pos, lsym[c-1][1], ltag, "line_tx_pos");
        check1(line_tx_neg, lsym[c-1][0], ltag, "line_tx_neg");
        decode(c - 1, lb ? ((c >= 2) ? lsym[c-2] : 2'b00) : rsym[c-1], ami);
        idx = c - 4;
        ed  = ais_q[c-1] ? 1'b1 : ((idx >= 0) ? dat[idx] : 1'b0);
        ecv = ais_q[c-1] ? 1'b0 : ((idx >= 0) ? cvb[idx] : 1'b0);
        rtag = ais_q[c-1] ? "R7" : (lb ? "R8" : "R5");
        check1(rx_data, ed, rtag, "rx_data");
        rtag = ais_q[c-1] ? "R7" : (lb ? "R8" : "R6");
        check1(rx_cv, ecv, rtag, "rx_cv");
      end
      if (c < n) begin
        if (directed && c < 30) begin
          tx_data = directed_bit(c);
          ones = 0;
        end else begin
          tx_data = ($urandom_range(99) < p_one);
          if ($urandom_range(99) < p_tog) ones = !ones;
        end
        tx_ones_en = ones;
        s[c+3] = tx_data | tx_ones_en;
        if ($urandom_range(99) < p_rx) rsym[c] = $urandom_range(1) ? 2'b10 : 2'b01;
        else rsym[c] = 2'b00;
        line_rx_pos = rsym[c][1];
        line_rx_neg = rsym[c][0];
        auto_rx_ones_en = ($urandom_range(3) == 0);
        rx_los = ($urandom_range(3) == 0);
        ais_q[c] = auto_rx_ones_en && rx_los && !lb;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    run_phase(1500, 1'b0, 1'b1, 50, 3, 30, 1'b1);
    run_phase(800,  1'b0, 1'b1, 12, 1, 30, 1'b1);
    run_phase(600,  1'b1, 1'b1, 50, 2, 30, 1'b0);
    run_phase(1500, 1'b0, 1'b0, 40, 2, 35, 1'b0);
    run_phase(500,  1'b1, 1'b0, 40, 2, 50, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule